// File: doc/BRIEF.md
# I2C slave byte-addressed memory

This block is the protocol front end and storage of a serial byte memory that sits on a two-wire I2C bus as a slave. It is fed with already-sampled SCL and SDA levels and with one-cycle strobes that mark bus start and stop conditions. It answers only to its own slave address, takes a two-byte word address and stores or returns bytes in an inferred register array. It drives the bus only through an open-drain pull-down request.

Writes can be a single byte or a run of bytes of any length. Reads can take the byte at the internal pointer with no address phase, or first load an address with a dummy write and a repeated start. Reads continue for as long as the master acknowledges. A write-protect input keeps every location unchanged, while the bus exchange runs as normal.

The array holds 2^ADDR_W bytes. The protocol address field is 13 bits wide, and the default ADDR_W is 11, so any address bits above the array width are ignored.

Top module: `i2c_byte_mem`

## Requirements
- R1: The block acknowledges a slave address byte only when bit 7 down to bit 4 equal 1010 and bits 3..1 equal devSel[2:0]. On any other address it never pulls SDA low until the next start.
- R2: Bit 0 of a matching slave address selects the direction. 0 means two word-address bytes follow. 1 means the block sends a data byte right after its acknowledge.
- R3: The first word-address byte supplies address bits 12..8 from its bits 4..0, and its bits 7..5 are ignored. The second byte supplies bits 7..0. Address bits at or above ADDR_W are ignored. The pointer takes the new address only when the second byte completes.
- R4: The acknowledge (SDA pulled low) for a matching slave address, for each word-address byte and for each write data byte starts at the SCL fall after the 8th rise of the byte. It ends at the SCL fall after the 9th rise.
- R5: Each write data byte is stored at the pointer, and the pointer then steps by one modulo 2^ADDR_W. A long run of writes wraps from the last location to location 0.
- R6: A read with no address phase returns the byte at the pointer, most significant bit first. Each bit is presented from an SCL fall, and SDA is pulled low for a 0 bit.
- R7: A write of slave address and two word-address bytes, then a repeated start and a read slave address, returns the byte at the loaded address.
- R8: When the master acknowledges a read byte, the next byte is sent from the next address, and the pointer wraps at the array end. The pointer steps by one after every read byte.
- R9: After the master does not acknowledge a read byte, the block releases SDA and stays quiet until a start or stop. Outside a transaction SDA is never pulled low.
- R10: With wpIn high, write data bytes are acknowledged and the pointer still steps, but no location changes.
- R11: A start strobe at any point abandons the transfer and begins slave address reception. A stop strobe returns to idle with the pointer kept, and an unfinished word address does not load the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL level |
| sdaIn | input | 1 | Sampled SDA level (the wired bus value) |
| startStb | input | 1 | One-cycle strobe: start or repeated start seen |
| stopStb | input | 1 | One-cycle strobe: stop seen |
| devSel | input | 3 | Pin-strapped select bits of the slave address |
| wpIn | input | 1 | Write protect, high blocks every store |
| sdaDrvLow | output | 1 | 1 requests the open-drain pull-down of SDA |

## Verification
The assertions check on every cycle the properties that need no memory contents. SDA is quiet outside a transaction and after a refused address. The acknowledge stays within the ninth-bit slot, and transmit stays within a read byte. A start or stop always lands in the right state, the pointer steps by exactly one per data byte, and a protected write leaves its location unchanged. The bench's reference model is needed for what depends on stored data and on the order of transactions. That covers the bit-by-bit read values, the pointer carried between transactions, wrap-around, the effect of the top address bits, and a pointer left unchanged by an aborted address phase.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_ADRHI,
    ST_ADRLO,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } phase_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftRx;
    logic latchHi;
    logic loadPtr;
    logic wrByte;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
  } strobe_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int WORD_ADR_W = 13;

endpackage

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic [2:0] devSel,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output strobe_t    st,
  output logic       sdaDrvLow
);

  phase_e     state;
  logic       sclQ;
  logic [3:0] bitCnt;
  logic       ackDrv;
  logic       txOn;
  logic       rwBit;
  logic       mAck;

  logic sclRise, sclFall, noCond, devHit, recvPhase, byteEnd, slotEnd;

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign noCond    = ~startStb & ~stopStb;
  assign devHit    = (rxByte[7:1] == {DEV_CODE, devSel});
  assign recvPhase = (state == ST_DEVADR) || (state == ST_ADRHI) ||
                     (state == ST_ADRLO)  || (state == ST_WDATA);
  assign byteEnd   = noCond && sclFall && (bitCnt == 4'd8);
  assign slotEnd   = noCond && sclFall && (bitCnt == 4'd9);

  always_comb begin
    st         = '0;
    st.shiftRx = noCond && recvPhase && sclRise && (bitCnt < 4'd8);
    st.latchHi = byteEnd && (state == ST_ADRHI);
    st.loadPtr = byteEnd && (state == ST_ADRLO);
    st.wrByte  = byteEnd && (state == ST_WDATA);
    st.incPtr  = st.wrByte ||
                 (noCond && (state == ST_RDATA) && sclRise && (bitCnt == 4'd8));
    st.loadTx  = slotEnd && (((state == ST_DEVADR) && rwBit) ||
                             ((state == ST_RDATA) && mAck));
    st.shiftTx = noCond && (state == ST_RDATA) && sclFall &&
                 (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
  end

  assign sdaDrvLow = ackDrv | (txOn & ~txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      sclQ   <= 1'b1;
      bitCnt <= '0;
      ackDrv <= 1'b0;
      txOn   <= 1'b0;
      rwBit  <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      sclQ <= sclIn;
      if (startStb) begin
        state  <= ST_DEVADR;
        bitCnt <= '0;
        ackDrv <= 1'b0;
        txOn   <= 1'b0;
      end else if (stopStb) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        ackDrv <= 1'b0;
        txOn   <= 1'b0;
      end else if (state != ST_IDLE && state != ST_WAIT) begin
        if (sclRise && bitCnt != 4'd9) bitCnt <= bitCnt + 4'd1;
        if (sclRise && bitCnt == 4'd8 && state == ST_RDATA) mAck <= ~sdaIn;
        if (byteEnd) begin
          if (state == ST_RDATA) txOn <= 1'b0;
          else if (state == ST_DEVADR && !devHit) state <= ST_IDLE;
          else begin
            ackDrv <= 1'b1;
            if (state == ST_DEVADR) rwBit <= rxByte[0];
          end
        end
        if (slotEnd) begin
          ackDrv <= 1'b0;
          bitCnt <= '0;
          case (state)
            ST_DEVADR: if (rwBit) begin
                         state <= ST_RDATA;
                         txOn  <= 1'b1;
                       end else state <= ST_ADRHI;
            ST_ADRHI:  state <= ST_ADRLO;
            ST_ADRLO:  state <= ST_WDATA;
            ST_RDATA:  if (mAck) txOn <= 1'b1;
                       else state <= ST_WAIT;
            default:   state <= state;
          endcase
        end
      end
    end
  end

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_WAIT) |-> !sdaDrvLow); // R9
  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    ackDrv |-> (bitCnt == 4'd8 || bitCnt == 4'd9)); // R4
  AST_NO_ACK_FOREIGN: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnd && state == ST_DEVADR && !devHit) |=> !sdaDrvLow); // R1
  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (state == ST_DEVADR && !sdaDrvLow)); // R11
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> (state == ST_IDLE)); // R11
  AST_TX_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    txOn |-> (state == ST_RDATA && bitCnt <= 4'd8)); // R6

endmodule

// File: rtl/i2cmem_dpath.sv
module i2cmem_dpath
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  input  logic       sdaIn,
  input  logic       wpIn,
  output logic [7:0] rxByte,
  output logic       txMsb
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        rxSh;
  logic [7:0]        txSh;
  logic [4:0]        hiReg;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        mem [DEPTH];

  assign rxByte = rxSh;
  assign txMsb  = txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh  <= '0;
      txSh  <= '0;
      hiReg <= '0;
      ptr   <= '0;
    end else begin
      if (st.shiftRx) rxSh <= {rxSh[6:0], sdaIn};
      if (st.latchHi) hiReg <= rxSh[4:0];
      if (st.loadPtr) ptr <= ADDR_W'({hiReg, rxSh});
      else if (st.incPtr) ptr <= ptr + 1'b1;
      if (st.loadTx) txSh <= mem[ptr];
      else if (st.shiftTx) txSh <= {txSh[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (st.wrByte && !wpIn) mem[ptr] <= rxSh;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.incPtr |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R5
  AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wpIn && st.wrByte) |=> (mem[$past(ptr)] == $past(mem[ptr]))); // R10

endmodule

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic [2:0] devSel,
  input  logic       wpIn,
  output logic       sdaDrvLow
);

  strobe_t    st;
  logic [7:0] rxByte;
  logic       txMsb;

  i2cmem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .startStb(startStb), .stopStb(stopStb), .devSel(devSel),
    .rxByte(rxByte), .txMsb(txMsb), .st(st), .sdaDrvLow(sdaDrvLow)
  );

  i2cmem_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .sdaIn(sdaIn), .wpIn(wpIn),
    .rxByte(rxByte), .txMsb(txMsb)
  );

endmodule

// File: tb/i2c_byte_mem_tb.sv
module i2c_byte_mem_tb;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] WR = 8'hAA;  // 1010 101 0
  localparam logic [7:0] RD = 8'hAB;  // 1010 101 1

  logic clk = 0, rstN = 0, sclIn = 1, sdaM = 1;
  logic startStb = 0, stopStb = 0, wpIn = 0;
  logic [2:0] devSel = 3'b101;
  logic sdaDrvLow;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaDrvLow;

  always #2 clk = ~clk;

  i2c_byte_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaBus),
    .startStb(startStb), .stopStb(stopStb), .devSel(devSel),
    .wpIn(wpIn), .sdaDrvLow(sdaDrvLow)
  );

  int nChk = 0, nBad = 0;
  logic checkEn = 0, expDrv = 0;
  string curReq = "R9";
  logic [7:0] refMem [DEPTH];
  int refPtr = 0;

  // per-cycle comparison against the model's expected pull-down
  always @(negedge clk) begin
    if (checkEn) begin
      nChk++;
      if (sdaDrvLow !== expDrv) begin
        nBad++;
        $display("FAIL %s: sdaDrvLow=%0b expected=%0b at %0t", curReq, sdaDrvLow, expDrv, $time);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic phaseLow(input logic m, input logic e);
    @(negedge clk); sclIn = 0; checkEn = 0;
    @(negedge clk); sdaM = m; expDrv = e; checkEn = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic phaseHigh();
    @(negedge clk); sclIn = 1; checkEn = 0;
    @(negedge clk); checkEn = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic startCond();
    phaseLow(1'b1, 1'b0); phaseHigh();
    @(negedge clk); sdaM = 0; startStb = 1; checkEn = 0;
    @(negedge clk); startStb = 0; expDrv = 0; checkEn = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic stopCond();
    phaseLow(1'b0, 1'b0); phaseHigh();
    @(negedge clk); sdaM = 1; stopStb = 1; checkEn = 0;
    @(negedge clk); stopStb = 0; checkEn = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, input logic ackExp, input string tag);
    curReq = tag;
    for (int i = 7; i >= 8 - n; i--) begin
      phaseLow(b[i], 1'b0); phaseHigh();
    end
    if (n == 8) begin
      if (ackExp) curReq = "R4";
      phaseLow(1'b1, ackExp); phaseHigh();
      curReq = tag;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ackExp, input string tag);
    sendBits(b, 8, ackExp, tag);
  endtask

  task automatic recvByte(input logic [7:0] exp, input bit ackIt, input string tag);
    logic [7:0] got;
    curReq = tag;
    for (int i = 7; i >= 0; i--) begin
      phaseLow(1'b1, ~exp[i]); phaseHigh();
      got[i] = sdaBus;
    end
    check(got == exp, tag, got, exp);
    phaseLow(~ackIt, 1'b0); phaseHigh();
  endtask

  task automatic readRun(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      recvByte(refMem[refPtr], k < n - 1, tag);
      refPtr = (refPtr + 1) % DEPTH;
    end
  endtask

  task automatic setAdr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    startCond();
    sendByte(WR, 1'b1, "R2");
    sendByte(hi, 1'b1, tag);
    sendByte(lo, 1'b1, tag);
    refPtr = int'({hi[4:0], lo}) % DEPTH;
  endtask

  task automatic doWrite(input logic [7:0] hi, input logic [7:0] lo,
                         input logic [7:0] d[$], input string tag);
    setAdr(hi, lo, "R3");
    foreach (d[k]) begin
      sendByte(d[k], 1'b1, tag);
      if (!wpIn) refMem[refPtr] = d[k];
      refPtr = (refPtr + 1) % DEPTH;
    end
    stopCond();
  endtask

  task automatic randRead(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
    setAdr(hi, lo, "R7");
    startCond();
    sendByte(RD, 1'b1, "R2");
    readRun(n, tag);
    stopCond();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(sdaDrvLow == 1'b0, "R9 reset", sdaDrvLow, 0);
    checkEn = 1;

    // R1: wrong select bits and wrong device code are never acknowledged
    startCond();
    sendByte(8'hA0, 1'b0, "R1");
    sendByte(8'h00, 1'b0, "R1");
    stopCond();
    startCond();
    sendByte(8'hBA, 1'b0, "R1");
    stopCond();

    // R5: three-byte write at 0x123
    q = '{8'h5A, 8'hC3, 8'h0F};
    doWrite(8'h01, 8'h23, q, "R5");

    // R7: random read of two bytes
    randRead(8'h01, 8'h23, 2, "R7");
    check(refPtr == 'h125, "R8 pointer", refPtr, 'h125);

    // R6: current-address read returns 0x0F
    startCond();
    sendByte(RD, 1'b1, "R2");
    readRun(1, "R6");
    stopCond();

    // R3/R5: top bits of the high byte ignored, page write wraps at array end
    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    doWrite(8'hE7, 8'hFE, q, "R5");
    check(refMem[0] == 8'h33, "R5 wrap model", refMem[0], 8'h33);
    // R8: sequential read across the wrap
    randRead(8'h07, 8'hFE, 4, "R8");

    // R10: protected write is acknowledged, discarded, pointer advances
    wpIn = 1;
    q = '{8'hFF, 8'hEE};
    doWrite(8'h01, 8'h23, q, "R10");
    wpIn = 0;
    startCond();
    sendByte(RD, 1'b1, "R2");
    readRun(1, "R10");
    randRead(8'h01, 8'h23, 2, "R10");

    // R9: after master NACK the slave stays quiet for further clocks
    randRead(8'h07, 8'hFE, 1, "R9");
    startCond();
    sendByte(RD, 1'b1, "R2");
    readRun(1, "R9");
    curReq = "R9";
    for (int i = 0; i < 9; i++) begin
      phaseLow(1'b1, 1'b0); phaseHigh();
    end
    stopCond();

    // R11: start in the middle of an address byte, pointer not loaded
    startCond();
    sendByte(WR, 1'b1, "R11");
    sendByte(8'h00, 1'b1, "R11");
    sendBits(8'h00, 4, 1'b0, "R11");
    startCond();
    sendByte(RD, 1'b1, "R11");
    readRun(1, "R11");
    stopCond();

    // R11: stop after the high byte, pointer kept
    startCond();
    sendByte(WR, 1'b1, "R11");
    sendByte(8'h01, 1'b1, "R11");
    stopCond();
    startCond();
    sendByte(RD, 1'b1, "R11");
    readRun(1, "R11");
    stopCond();

    repeat (5) @(negedge clk);
    checkEn = 0;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule